// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block turns 32-bit words taken from a transmit FIFO into a framed serial audio stream. Each frame holds one or two channel slots. Every slot carries a word of programmable length, most significant bit first, and the bits left over in the slot are padded with a programmable fill level. As master, the block makes the bit clock by dividing either the system clock or a sampled external clock, and it issues a one-slot frame-sync pulse. Frame sync runs in one of two ways. In burst mode a frame starts only when data is ready. In free-running mode frames run back to back. As slave, the block follows falling edges of an incoming bit clock and restarts its frame whenever incoming frame sync is seen high on such an edge.

When the FIFO is empty (or transmit is disabled) at the moment a frame starts, every channel of that frame carries the fill level. A split option sends each FIFO word as two 16-bit serial words, the low half first, so that one FIFO entry feeds a stereo pair.

Top module: `aud_ser_tx`

## Requirements
- R1: While reset is asserted, `sck_out`, `fs_out`, `sdo` and `fifo_pop` are all 0.
- R2: In master mode with the bit clock running, `sck_out` toggles once every `cfg_div`+1 source events. A source event is every system clock cycle when `cfg_ext_src`=0. When `cfg_ext_src`=1, it is every rising edge of `ext_clk`, seen through a two-stage synchroniser.
- R3: In master mode, `sdo` and `fs_out` change only on the clock cycle in which `sck_out` falls.
- R4: Within a channel slot of `cfg_chan_len` bits, the first `cfg_word_len` slots carry bits `cfg_word_len`-1 down to 0 of the word (the word is held in the low bits of the FIFO entry). The remaining slots carry `cfg_fill`. Outside a frame, `sdo` carries `cfg_fill`.
- R5: With `cfg_split`=1, a FIFO entry is sent as bits 15:0 in one channel and bits 31:16 in the next channel. The FIFO is popped only for the low half.
- R6: A frame is channel 0 only (`cfg_two_sub`=0) or channel 0 then channel 1 (`cfg_two_sub`=1). In master mode `fs_out` is 1 for exactly the first bit slot of each frame.
- R7: In master burst mode (`cfg_free_run`=0), a frame starts at a boundary only when `start`=1, `tx_en`=1, and either the FIFO is non-empty or a high half is pending. A frame already started runs to its end.
- R8: In master free-running mode, frames follow each other with no gap for as long as `start`=1.
- R9: In master mode, once `start`=0 and the current frame has ended, `sck_out` stays 0 and no frame sync is issued.
- R10: If at frame start `tx_en`=0, or the FIFO is empty with no high half pending, every channel of that frame carries `cfg_fill` and no pop occurs during that frame.
- R11: In slave mode (`cfg_master`=0), each falling edge of `sck_in` advances one bit slot. `fs_in` high on such an edge starts a frame at channel 0. `sck_out` and `fs_out` stay 0.
- R12: `fifo_pop` is a one-cycle pulse at the start of a channel that needs a new FIFO entry. It never occurs while `fifo_empty`=1. A channel that needs an entry but finds the FIFO empty carries `cfg_fill`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_free_run | input | 1 | Master frame sync: 1 = free-running, 0 = burst |
| cfg_two_sub | input | 1 | 1 = two channels per frame |
| cfg_split | input | 1 | 1 = send each entry as two 16-bit halves |
| cfg_ext_src | input | 1 | Master divider source: 1 = ext_clk, 0 = clk |
| cfg_fill | input | 1 | Level used for padding and underrun |
| cfg_div | input | DIV_W | Bit-clock half period minus one, in source events |
| cfg_chan_len | input | LEN_W | Bits per channel slot (1 or more) |
| cfg_word_len | input | LEN_W | Bits per serial word (1 to 32) |
| start | input | 1 | Master run request |
| tx_en | input | 1 | Transmit enable |
| ext_clk | input | 1 | External divider source |
| sck_in | input | 1 | Slave bit clock |
| fs_in | input | 1 | Slave frame sync |
| fifo_data | input | DATA_W | Head entry of the transmit FIFO |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_pop | output | 1 | Pop strobe to the FIFO |
| sck_out | output | 1 | Master bit clock |
| fs_out | output | 1 | Master frame sync |
| sdo | output | 1 | Serial data |

## Verification
The hardest case to reach is the burst boundary where the FIFO has just run dry but the high half of a split entry is still owed. Close to it is the frame that starts on the last entry and then finds the FIFO empty at its second channel. The stimulus reaches both by loading an odd number of entries before raising `start`: three entries with splitting on, and one entry left over for a two-channel frame. A behavioural model tracks frame position, pending halves and FIFO contents and is compared with every output on every clock. Slave framing is driven by a bench generator that places `fs_in` on chosen falling edges of `sck_in`, with the FIFO drained so that underrun frames follow data frames.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
   // Slot descriptor passed from the frame sequencer to the data path
   typedef struct packed {
      logic emit;   // a bit slot of a frame is sent on this tick
      logic ur;     // the frame this slot belongs to started in underrun
   } slot_t;
endpackage

// File: rtl/aud_bclk_gen.sv
module aud_bclk_gen #(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             ext_sel,
   input  logic             ext_clk,
   input  logic [DIV_W-1:0] div,
   output logic             sck_o,
   output logic             fall_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_q;
   logic                   src_en;
   logic                   wrap;
   logic                   sck_q;
   logic [DIV_W-1:0]       cnt_q;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= ext_clk;
      end
   end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_q <= 1'b0;
      else        ext_q <= sync_q[SYNC_STAGES-1];
   end

   assign src_en = ext_sel ? (sync_q[SYNC_STAGES-1] && !ext_q) : 1'b1;
   assign wrap   = run && src_en && (cnt_q == div);
   assign fall_o = wrap && sck_q;
   assign sck_o  = sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else if (src_en) begin
         if (cnt_q == div) begin
            cnt_q <= '0;
            sck_q <= !sck_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R2
   hold_between_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !src_en) |=> $stable(sck_o));
endmodule

// File: rtl/aud_frame_ctl.sv
module aud_frame_ctl #(
   parameter int LEN_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                is_master,
   input  logic                free_run,
   input  logic                two_sub,
   input  logic                start,
   input  logic                tx_en,
   input  logic                fifo_empty,
   input  logic                pend_hi,
   input  logic                fs_in,
   input  logic [LEN_W-1:0]    chan_len,
   output logic                active_o,
   output logic                fs_o,
   output aud_tx_pkg::slot_t   slot_o,
   output logic [LEN_W-1:0]    slot_bit_o
);
   logic             active_q;
   logic             sub_q;
   logic             fur_q;
   logic             fs_q;
   logic [LEN_W-1:0] bit_q;
   logic             end_ch;
   logic             last;
   logic             can_go;
   logic             go;
   logic             adv;
   logic             fur_new;

   assign end_ch  = (bit_q == chan_len - 1'b1);
   assign last    = active_q && end_ch && (sub_q == two_sub);
   assign fur_new = !tx_en || (fifo_empty && !pend_hi);

   always_comb begin
      if (!is_master)    can_go = 1'b0;
      else if (free_run) can_go = start;
      else               can_go = start && tx_en && (!fifo_empty || pend_hi);
   end

   assign go  = tick && (is_master ? ((!active_q || last) && can_go) : fs_in);
   assign adv = tick && active_q && !last && !go;

   assign slot_bit_o  = (go || end_ch) ? '0 : bit_q + 1'b1;
   assign slot_o.emit = go || adv;
   assign slot_o.ur   = go ? fur_new : fur_q;
   assign active_o    = active_q;
   assign fs_o        = fs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sub_q    <= 1'b0;
         fur_q    <= 1'b0;
         bit_q    <= '0;
         fs_q     <= 1'b0;
      end else begin
         if (go) begin
            active_q <= 1'b1;
            bit_q    <= '0;
            sub_q    <= 1'b0;
            fur_q    <= fur_new;
         end else if (adv) begin
            bit_q <= slot_bit_o;
            if (end_ch) sub_q <= 1'b1;
         end else if (tick) begin
            active_q <= 1'b0;
         end
         if (tick) fs_q <= go && is_master;
      end
   end

   // R7
   burst_start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_master && !free_run && $rose(fs_o)) |->
         $past(start && tx_en && (!fifo_empty || pend_hi)));
endmodule

// File: rtl/aud_tx_datapath.sv
module aud_tx_datapath #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  aud_tx_pkg::slot_t slot,
   input  logic [LEN_W-1:0]  slot_bit,
   input  logic [LEN_W-1:0]  word_len,
   input  logic              split,
   input  logic              fill,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              fifo_empty,
   output logic              sdo_o,
   output logic              pop_o,
   output logic              pend_o
);
   localparam int HALF_W = DATA_W / 2;
   localparam int IDX_W  = $clog2(DATA_W);

   logic [DATA_W-1:0] cur_q;
   logic [DATA_W-1:0] word;
   logic [HALF_W-1:0] hi_q;
   logic              half_q;
   logic              chfill_q;
   logic              sdo_q;
   logic              pop_q;
   logic              ch_start;
   logic              use_hi;
   logic              need_pop;
   logic              take;
   logic              ch_fill;
   logic              bitv;
   logic [IDX_W-1:0]  idx;

   assign ch_start = (slot_bit == '0);
   assign use_hi   = split && half_q;
   assign need_pop = ch_start && !slot.ur && !use_hi;
   assign take     = slot.emit && need_pop && !fifo_empty;

   always_comb begin
      if (!ch_start)   word = cur_q;
      else if (use_hi) word = {{HALF_W{1'b0}}, hi_q};
      else if (split)  word = {{HALF_W{1'b0}}, fifo_data[HALF_W-1:0]};
      else             word = fifo_data;
      ch_fill = ch_start ? (slot.ur || (need_pop && fifo_empty)) : chfill_q;
      idx     = IDX_W'(word_len - 1'b1 - slot_bit);
      bitv    = (!ch_fill && (slot_bit < word_len)) ? word[idx] : fill;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q    <= '0;
         hi_q     <= '0;
         half_q   <= 1'b0;
         chfill_q <= 1'b0;
         sdo_q    <= 1'b0;
         pop_q    <= 1'b0;
      end else begin
         pop_q <= take;
         if (tick) sdo_q <= slot.emit ? bitv : fill;
         if (slot.emit && ch_start) begin
            cur_q    <= word;
            chfill_q <= ch_fill;
         end
         if (!split) begin
            half_q <= 1'b0;
         end else if (take) begin
            half_q <= 1'b1;
            hi_q   <= fifo_data[DATA_W-1:HALF_W];
         end else if (slot.emit && ch_start && !slot.ur && use_hi) begin
            half_q <= 1'b0;
         end
      end
   end

   assign sdo_o  = sdo_q;
   assign pop_o  = pop_q;
   assign pend_o = half_q;

   // R12
   pop_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_o |-> $past(!fifo_empty));
   // R12
   pop_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_o |=> !pop_o);
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
   parameter int DATA_W      = 32,
   parameter int LEN_W       = 6,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic              cfg_free_run,
   input  logic              cfg_two_sub,
   input  logic              cfg_split,
   input  logic              cfg_ext_src,
   input  logic              cfg_fill,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [LEN_W-1:0]  cfg_chan_len,
   input  logic [LEN_W-1:0]  cfg_word_len,
   input  logic              start,
   input  logic              tx_en,
   input  logic              ext_clk,
   input  logic              sck_in,
   input  logic              fs_in,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              fifo_empty,
   output logic              fifo_pop,
   output logic              sck_out,
   output logic              fs_out,
   output logic              sdo
);
   if ((DATA_W % 2) != 0 || DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be even and at least 2");
   end
   if ((1 << LEN_W) <= DATA_W) begin : g_bad_len
      $error("LEN_W too narrow to hold a full word length");
   end

   aud_tx_pkg::slot_t slot;
   logic [LEN_W-1:0]  slot_bit;
   logic              sckin_q;
   logic              s_fall;
   logic              m_fall;
   logic              tick;
   logic              active;
   logic              pend;
   logic              run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sckin_q <= 1'b0;
      else        sckin_q <= sck_in;
   end

   assign s_fall = sckin_q && !sck_in;
   assign tick   = cfg_master ? m_fall : s_fall;
   assign run    = cfg_master && (start || active);

   aud_bclk_gen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_bclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .ext_sel (cfg_ext_src),
      .ext_clk (ext_clk),
      .div     (cfg_div),
      .sck_o   (sck_out),
      .fall_o  (m_fall)
   );

   aud_frame_ctl #(.LEN_W(LEN_W)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .is_master  (cfg_master),
      .free_run   (cfg_free_run),
      .two_sub    (cfg_two_sub),
      .start      (start),
      .tx_en      (tx_en),
      .fifo_empty (fifo_empty),
      .pend_hi    (pend),
      .fs_in      (fs_in),
      .chan_len   (cfg_chan_len),
      .active_o   (active),
      .fs_o       (fs_out),
      .slot_o     (slot),
      .slot_bit_o (slot_bit)
   );

   aud_tx_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_data (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .slot       (slot),
      .slot_bit   (slot_bit),
      .word_len   (cfg_word_len),
      .split      (cfg_split),
      .fill       (cfg_fill),
      .fifo_data  (fifo_data),
      .fifo_empty (fifo_empty),
      .sdo_o      (sdo),
      .pop_o      (fifo_pop),
      .pend_o     (pend)
   );

   // R3
   data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && !$stable(sdo)) |-> $fell(sck_out));
   // R3
   sync_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && !$stable(fs_out)) |-> $fell(sck_out));
   // R11
   slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_master |-> (!sck_out && !fs_out));
endmodule

// File: tb/sim_aud_ser_tx.sv
module sim_aud_ser_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_master = 1'b1, cfg_free_run = 1'b0, cfg_two_sub = 1'b0;
   logic        cfg_split = 1'b0, cfg_ext_src = 1'b0, cfg_fill = 1'b0;
   logic [7:0]  cfg_div = 8'd0;
   logic [5:0]  cfg_chan_len = 6'd8, cfg_word_len = 6'd8;
   logic        start = 1'b0, tx_en = 1'b0;
   logic        ext_clk = 1'b0, sck_in = 1'b0, fs_in = 1'b0;
   logic [31:0] fifo_data = 32'd0;
   logic        fifo_empty = 1'b1;
   logic        fifo_pop, sck_out, fs_out, sdo;

   int n_tests = 0, n_fail = 0, cyc = 0;
   logic [31:0] q[$];

   // model state
   int          m_cnt, m_bit;
   logic        m_sck, m_active, m_sub, m_fur, m_pend, m_chfill, m_sdo, m_fs, m_pop;
   logic        m_extq, m_sckq;
   logic [1:0]  m_sync;
   logic [31:0] m_word;
   logic [15:0] m_hi;
   // monitors
   int   fs_rises, pops, sck_hi, fs_hi;
   logic prev_fs;
   // generators
   logic sl_on = 1'b0, ext_on = 1'b0;
   int   sl_ph = 0, sl_bit = 0, sl_frame = 12, ex_ph = 0;

   always #10 clk = !clk;

   aud_ser_tx u0 (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_free_run(cfg_free_run),
      .cfg_two_sub(cfg_two_sub), .cfg_split(cfg_split), .cfg_ext_src(cfg_ext_src),
      .cfg_fill(cfg_fill), .cfg_div(cfg_div), .cfg_chan_len(cfg_chan_len),
      .cfg_word_len(cfg_word_len), .start(start), .tx_en(tx_en), .ext_clk(ext_clk),
      .sck_in(sck_in), .fs_in(fs_in), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
      .fifo_pop(fifo_pop), .sck_out(sck_out), .fs_out(fs_out), .sdo(sdo)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cnt = 0; m_bit = 0; m_sck = 0; m_active = 0; m_sub = 0; m_fur = 0;
      m_pend = 0; m_chfill = 0; m_sdo = 0; m_fs = 0; m_pop = 0;
      m_extq = 0; m_sckq = 0; m_sync = 2'b00; m_word = 0; m_hi = 0; prev_fs = 0;
   endtask

   task automatic model_tick();
      bit last, go, emit;
      last = m_active && (m_bit == int'(cfg_chan_len) - 1) && (m_sub == cfg_two_sub);
      go = 0;
      if (!cfg_master) go = fs_in;
      else if (!m_active || last)
         go = cfg_free_run ? start : (start && tx_en && (!fifo_empty || m_pend));
      emit = 1;
      if (go) begin
         m_active = 1; m_bit = 0; m_sub = 0;
         m_fur = !tx_en || (fifo_empty && !m_pend);
      end else if (m_active && !last) begin
         if (m_bit == int'(cfg_chan_len) - 1) begin m_bit = 0; m_sub = 1; end
         else m_bit++;
      end else begin
         m_active = 0; emit = 0;
      end
      m_fs = go && cfg_master;
      if (!emit) m_sdo = cfg_fill;
      else begin
         if (m_bit == 0) begin
            if (m_fur) m_chfill = 1;
            else if (cfg_split && m_pend) begin m_word = {16'h0, m_hi}; m_pend = 0; m_chfill = 0; end
            else if (fifo_empty) m_chfill = 1;
            else begin
               m_pop = 1; m_chfill = 0;
               if (cfg_split) begin m_word = {16'h0, fifo_data[15:0]}; m_hi = fifo_data[31:16]; m_pend = 1; end
               else m_word = fifo_data;
            end
         end
         m_sdo = (!m_chfill && m_bit < int'(cfg_word_len)) ? m_word[int'(cfg_word_len) - 1 - m_bit] : cfg_fill;
      end
   endtask

   // reference model, compared on every clock away from the active edge
   always @(negedge clk) begin
      bit src_en, s_fall, run, fall, tick;
      cyc++;
      if (cyc > 150000) begin
         chk(0, "watchdog", cyc, 150000);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
      if (!rst_n) model_reset();
      else begin
         src_en = cfg_ext_src ? (m_sync[1] && !m_extq) : 1'b1;
         m_extq = m_sync[1]; m_sync[1] = m_sync[0]; m_sync[0] = ext_clk;
         s_fall = m_sckq && !sck_in; m_sckq = sck_in;
         run = cfg_master && (start || m_active);
         fall = 0;
         if (!run) begin m_cnt = 0; m_sck = 0; end
         else if (src_en) begin
            if (m_cnt == int'(cfg_div)) begin fall = m_sck; m_cnt = 0; m_sck = !m_sck; end
            else m_cnt++;
         end
         tick = cfg_master ? fall : s_fall;
         m_pop = 0;
         if (tick) model_tick();
         if (!cfg_split) m_pend = 0;
         chk(sck_out == m_sck, "R2/R9/R11 sck_out", sck_out, m_sck);
         chk(fs_out == m_fs, "R6/R7/R8 fs_out", fs_out, m_fs);
         chk(sdo == m_sdo, "R4/R5/R10 sdo", sdo, m_sdo);
         chk(fifo_pop == m_pop, "R12 fifo_pop", fifo_pop, m_pop);
         if (m_pop && q.size() > 0) void'(q.pop_front());
         if (fifo_pop) pops++;
         if (fs_out && !prev_fs) fs_rises++;
         prev_fs = fs_out;
         if (sck_out) sck_hi++;
         if (fs_out) fs_hi++;
      end
      fifo_empty = (q.size() == 0);
      fifo_data  = fifo_empty ? 32'd0 : q[0];
   end

   // slave bit clock / frame sync and external clock generators
   always @(negedge clk) begin
      #2;
      if (!sl_on) begin sck_in = 0; fs_in = 0; sl_ph = 0; sl_bit = 0; end
      else if (++sl_ph == 3) begin
         sl_ph = 0;
         sck_in = !sck_in;
         if (!sck_in) begin fs_in = (sl_bit % sl_frame) == 0; sl_bit++; end
      end
      if (!ext_on) begin ext_clk = 0; ex_ph = 0; end
      else if (++ex_ph == 3) begin ex_ph = 0; ext_clk = !ext_clk; end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk); #1;
      rst_n = 0; start = 0; tx_en = 0; sl_on = 0; ext_on = 0;
      q.delete();
      wait_cyc(2);
      // R1
      chk(sck_out == 0 && fs_out == 0 && sdo == 0 && fifo_pop == 0, "R1 reset outputs",
          {sck_out, fs_out, sdo, fifo_pop}, 0);
      fs_rises = 0; pops = 0; sck_hi = 0; fs_hi = 0;
   endtask

   task automatic release_reset();
      rst_n = 1;
      wait_cyc(1);
   endtask

   initial begin
      int snap;
      // S1/S2: master burst, two channels, short words padded with 1
      do_reset();
      cfg_master = 1; cfg_free_run = 0; cfg_two_sub = 1; cfg_split = 0; cfg_ext_src = 0;
      cfg_fill = 1; cfg_div = 8'd1; cfg_chan_len = 6'd8; cfg_word_len = 6'd6;
      q.push_back(32'h0000_002D); q.push_back(32'hFFFF_FFC0);
      q.push_back(32'h0000_0015); q.push_back(32'h0000_003A);
      release_reset();
      start = 1; tx_en = 1;
      wait_cyc(300);
      chk(pops == 4, "R12 burst pops", pops, 4);
      chk(fs_rises == 2, "R6 burst frames", fs_rises, 2);
      wait_cyc(200);
      chk(fs_rises == 2, "R7 no frame on empty FIFO", fs_rises, 2);
      start = 0;
      wait_cyc(20);
      snap = sck_hi;
      wait_cyc(100);
      chk(sck_hi == snap, "R9 clock stopped", sck_hi, snap);

      // S3: split halves, one channel per frame, odd entry count
      do_reset();
      cfg_two_sub = 0; cfg_split = 1; cfg_fill = 0; cfg_div = 8'd0;
      cfg_chan_len = 6'd16; cfg_word_len = 6'd16;
      q.push_back(32'hA5C3_1234); q.push_back(32'h8001_7FFE); q.push_back(32'h0F0F_F0F0);
      release_reset();
      start = 1; tx_en = 1;
      wait_cyc(400);
      chk(pops == 3, "R5 one pop per two halves", pops, 3);
      chk(fs_rises == 6, "R5 pending high half starts frame", fs_rises, 6);

      // S4: free running on the external source, underrun after two entries
      do_reset();
      cfg_split = 0; cfg_two_sub = 1; cfg_free_run = 1; cfg_ext_src = 1; cfg_fill = 0;
      cfg_div = 8'd0; cfg_chan_len = 6'd4; cfg_word_len = 6'd3;
      q.push_back(32'h0000_0005); q.push_back(32'h0000_0006);
      release_reset();
      ext_on = 1; start = 1; tx_en = 1;
      wait_cyc(1000);
      chk(fs_rises >= 8, "R8 back to back frames", fs_rises, 8);
      chk(pops == 2, "R10 no pop in underrun frames", pops, 2);
      start = 0;
      wait_cyc(150);
      snap = fs_rises;
      wait_cyc(200);
      chk(fs_rises == snap, "R9 no frame sync after stop", fs_rises, snap);
      chk(sck_out == 0, "R9 clock low after stop", sck_out, 0);

      // S5: transmit disabled, then a mid-frame underrun
      do_reset();
      cfg_free_run = 0; cfg_ext_src = 0; cfg_fill = 1; cfg_div = 8'd1;
      cfg_chan_len = 6'd8; cfg_word_len = 6'd8;
      q.push_back(32'h0000_0081); q.push_back(32'h0000_0042); q.push_back(32'h0000_00E7);
      release_reset();
      start = 1; tx_en = 0;
      wait_cyc(200);
      chk(fs_rises == 0, "R7 no burst frame with tx_en=0", fs_rises, 0);
      chk(pops == 0, "R7 no pop with tx_en=0", pops, 0);
      tx_en = 1;
      wait_cyc(300);
      chk(pops == 3, "R12 empty channel filled", pops, 3);
      chk(fs_rises == 2, "R7 frame completes after underrun", fs_rises, 2);

      // S6: slave mode, data then underrun frames
      do_reset();
      cfg_master = 0; cfg_two_sub = 1; cfg_fill = 1; cfg_chan_len = 6'd6; cfg_word_len = 6'd5;
      sl_frame = 12;
      q.push_back(32'h0000_0013); q.push_back(32'h0000_000C); q.push_back(32'h0000_001F);
      release_reset();
      tx_en = 1; sl_on = 1;
      wait_cyc(600);
      chk(pops == 3, "R11 slave pops", pops, 3);
      chk(sck_hi == 0 && fs_hi == 0, "R11 outputs quiet in slave", sck_hi + fs_hi, 0);
      sl_on = 0;
      wait_cyc(5);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule